// File: doc/BRIEF.md
# Small-Page NAND Flash Command Interface

This block is a synthesizable device-side model of a byte-wide NAND flash command port. It is for system benches and for FPGA stand-ins for a removable flash card. A host drives chip enable, command latch, address latch, write strobe, read strobe and write protect, together with an 8-bit data bus. The data bus is split into `io_in`, `io_out` and an output enable. All pins are sampled on a fast system clock. A rising write strobe latches a command, an address or a data byte. A rising read strobe advances the output pointer. Behind the port sits a small cell array made of pages of 528 bytes. Each page has a lower half (columns 0–255), an upper half (256–511) and a spare field (512–527). The counts of pages per block and blocks are scaled down by parameters.

The control is one state machine. Its states are: `ST_IDLE`, `ST_RD_ADDR`, `ST_RD_BUSY`, `ST_RD_DATA`, `ST_PG_ADDR`, `ST_PG_DATA`, `ST_PG_BUSY`, `ST_ER_ADDR`, `ST_ER_BUSY`, `ST_ID_ADDR`, `ST_ID_DATA` and `ST_RST_BUSY`. Its transitions are:
- Read-pointer commands go to `ST_RD_ADDR`. The third address byte goes to `ST_RD_BUSY`. The end of the busy time goes to `ST_RD_DATA`. Reading past column 527 goes back to `ST_RD_BUSY` for the next page.
- Program setup goes to `ST_PG_ADDR`. The first data byte goes to `ST_PG_DATA`. The start command goes to `ST_PG_BUSY`, which returns to `ST_IDLE` when done.
- Erase setup goes to `ST_ER_ADDR`. The start command goes to `ST_ER_BUSY`, which returns to `ST_IDLE`.
- The ID command goes to `ST_ID_ADDR`, and one address byte goes to `ST_ID_DATA`.
- The reset command goes to `ST_RST_BUSY` from any state.
- A write-protect abort, or an unknown or misplaced command, goes to `ST_IDLE`.

A second register selects what the read strobe presents: nothing, array data, the status byte or the ID bytes.

Top module: `nand_cmd_if`

## Requirements
- R1: After reset the busy pull-down is released, and `io_oe` stays low even with the read strobe low.
- R2: Command 00H followed by three address bytes (column, page byte, high byte) holds busy for about READ_CYC cycles. Each read-strobe pulse then returns one array byte, starting at the given column of the lower half. The page within the block is address byte 2 bits [PG_BLK_W-1:0]. The block number is byte 2 bits starting at bit 5.
- R3: Command 01H places the column at 256 plus the column byte. The pointer falls back to the lower-half area once that column is latched, so the next program or read uses the lower half.
- R4: Command 50H places the column at 512 plus bits [3:0] of the column byte. This area stays selected for later operations until a 00H command.
- R5: A serial read that passes column 527 goes busy for a read time, then continues at column 0 of the next page.
- R6: 80H, three address bytes, data bytes and 10H hold busy for about PROG_CYC cycles. Programming can only clear bits: the stored byte becomes old AND new.
- R7: 60H, two page-address bytes and D0H hold busy for about ERASE_CYC cycles. All bytes of the addressed block become FFH.
- R8: After 70H, the read strobe returns the status byte. Bit 7 is the write-protect pin level. Bit 6 is 1 when ready. Bit 0 is 1 for fail, and is forced to 0 while busy. The other bits are 0.
- R9: 90H and one address byte, then successive read pulses, return 98H, 76H, A5H and then 00H.
- R10: FFH, accepted even while busy, aborts the current operation. It holds busy for about RST_CYC cycles, clears the fail bit and restores the lower-half pointer area.
- R11: With the write-protect pin low, 10H and D0H start nothing and set the fail bit. Pulling the pin low during program or erase busy ends it within two cycles and sets the fail bit.
- R12: An unknown command byte returns the machine to idle. The bus is not driven on a following read strobe.
- R13: An address byte beyond the third for a read is ignored.
- R14: `io_oe` is high only while chip enable and read strobe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, latching on its rising edge |
| re_n | input | 1 | Read strobe, data valid while low, advancing on rise |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte bus from host |
| io_out | output | 8 | Byte bus to host |
| io_oe | output | 1 | Drive enable for `io_out` |
| rb_pull_low | output | 1 | Open-drain ready/busy: 1 pulls the line low (busy) |

## Verification
A wrong state or a stuck pointer area shows at the data bus on the very next read-strobe pulse, as a byte from the wrong column or page, or as a bus left undriven. A busy timer or walker fault shows as a busy window of the wrong length, measured in clock cycles right after the start command. A lost write-protect or fail bit shows in the status byte read straight after the refused or aborted operation.

// File: rtl/nand_pkg.sv
package nand_pkg;
    localparam int PAGE_B = 528;
    localparam int COL_W  = 10;

    localparam logic [7:0] CMD_RD_LO   = 8'h00;
    localparam logic [7:0] CMD_RD_HI   = 8'h01;
    localparam logic [7:0] CMD_RD_SP   = 8'h50;
    localparam logic [7:0] CMD_PG_SET  = 8'h80;
    localparam logic [7:0] CMD_PG_GO   = 8'h10;
    localparam logic [7:0] CMD_ER_SET  = 8'h60;
    localparam logic [7:0] CMD_ER_GO   = 8'hD0;
    localparam logic [7:0] CMD_STAT    = 8'h70;
    localparam logic [7:0] CMD_ID      = 8'h90;
    localparam logic [7:0] CMD_RST     = 8'hFF;

    localparam logic [7:0] ID_B0 = 8'h98;
    localparam logic [7:0] ID_B1 = 8'h76;
    localparam logic [7:0] ID_B2 = 8'hA5;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_ADDR, ST_RD_BUSY, ST_RD_DATA,
        ST_PG_ADDR, ST_PG_DATA, ST_PG_BUSY,
        ST_ER_ADDR, ST_ER_BUSY, ST_ID_ADDR, ST_ID_DATA, ST_RST_BUSY
    } st_e;

    typedef enum logic [1:0] {AREA_LO, AREA_HI, AREA_SP} area_e;
    typedef enum logic [1:0] {OUT_NONE, OUT_DATA, OUT_STAT, OUT_ID} omode_e;
endpackage

// File: rtl/nand_pin_edge.sv
module nand_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic re_n,
    output logic we_rise,
    output logic re_rise
);
    logic we_q, re_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    assign we_rise = !ce_n && we_n && !we_q;
    assign re_rise = !ce_n && re_n && !re_q;
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clear,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nand_array.sv
module nand_array #(
    parameter int DEPTH = 2112,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
    import nand_pkg::*;
#(
    parameter int PG_BLK_W  = 1,
    parameter int BLK_W     = 1,
    parameter int READ_CYC  = 40,
    parameter int PROG_CYC  = 600,
    parameter int ERASE_CYC = 1200,
    parameter int RST_CYC   = 20,
    parameter int TMR_W     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       rb_pull_low
);
    localparam int PG_W   = PG_BLK_W + BLK_W;
    localparam int N_PAGE = 1 << PG_W;
    localparam int DEPTH  = N_PAGE * PAGE_B;
    localparam int AW     = $clog2(DEPTH);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAGE_B - 1);

    st_e    st, st_nx;
    area_e  area;
    omode_e omode;
    logic [COL_W-1:0]    col, walk_col;
    logic [PG_W-1:0]     page, walk_page;
    logic [PG_BLK_W-1:0] walk_pib;
    logic [1:0]          addr_cnt, id_idx;
    logic                fail, walk_done;
    logic [7:0]          pgbuf [PAGE_B];

    logic we_rise, re_rise, is_cmd, is_adr, is_dat;
    logic busy_st, wp_kill, cmd_live, rst_cmd, busy_done, rd_wrap;
    logic go_pg_ok, go_er_ok, enter_busy, walking, mem_we, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic [AW-1:0]    mem_addr;
    logic [7:0]       mem_wdata, mem_rdata;

    function automatic logic busy_of(st_e s);
        return (s == ST_RD_BUSY) || (s == ST_PG_BUSY) ||
               (s == ST_ER_BUSY) || (s == ST_RST_BUSY);
    endfunction

    nand_pin_edge u_edge (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
        .we_rise(we_rise), .re_rise(re_rise)
    );

    assign is_cmd    = we_rise && cle && !ale;
    assign is_adr    = we_rise && ale && !cle;
    assign is_dat    = we_rise && !ale && !cle;
    assign busy_st   = busy_of(st);
    assign wp_kill   = !wp_n && (st == ST_PG_BUSY || st == ST_ER_BUSY);
    assign rst_cmd   = is_cmd && (io_in == CMD_RST);
    assign cmd_live  = is_cmd && !busy_st && (io_in != CMD_STAT) && (io_in != CMD_RST);
    assign busy_done = tmr_zero && walk_done;
    assign rd_wrap   = (st == ST_RD_DATA) && re_rise && (omode == OUT_DATA) && (col == COL_LAST);
    assign go_pg_ok  = (st == ST_PG_DATA) || (st == ST_PG_ADDR && addr_cnt == 2'd3);
    assign go_er_ok  = (st == ST_ER_ADDR) && (addr_cnt >= 2'd2);

    // next-state logic
    always_comb begin
        st_nx = st;
        if (rst_cmd) begin
            st_nx = ST_RST_BUSY;
        end else if (wp_kill) begin
            st_nx = ST_IDLE;
        end else if (cmd_live) begin
            case (io_in)
                CMD_RD_LO, CMD_RD_HI, CMD_RD_SP: st_nx = ST_RD_ADDR;
                CMD_PG_SET: st_nx = ST_PG_ADDR;
                CMD_ER_SET: st_nx = ST_ER_ADDR;
                CMD_ID:     st_nx = ST_ID_ADDR;
                CMD_PG_GO:  st_nx = (go_pg_ok && wp_n) ? ST_PG_BUSY : ST_IDLE;
                CMD_ER_GO:  st_nx = (go_er_ok && wp_n) ? ST_ER_BUSY : ST_IDLE;
                default:    st_nx = ST_IDLE;
            endcase
        end else begin
            unique case (st)
                ST_RD_ADDR:  if (is_adr && addr_cnt == 2'd2) st_nx = ST_RD_BUSY;
                ST_ID_ADDR:  if (is_adr) st_nx = ST_ID_DATA;
                ST_PG_ADDR:  if (is_dat && addr_cnt == 2'd3) st_nx = ST_PG_DATA;
                ST_RD_BUSY:  if (busy_done) st_nx = ST_RD_DATA;
                ST_PG_BUSY, ST_ER_BUSY, ST_RST_BUSY:
                             if (busy_done) st_nx = ST_IDLE;
                ST_RD_DATA:  if (rd_wrap) st_nx = ST_RD_BUSY;
                default:     st_nx = st;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // busy timing and array walker
    assign enter_busy = busy_of(st_nx) && ((st_nx != st) || rst_cmd);

    always_comb begin
        case (st_nx)
            ST_RD_BUSY: tmr_val = TMR_W'(READ_CYC);
            ST_PG_BUSY: tmr_val = TMR_W'(PROG_CYC);
            ST_ER_BUSY: tmr_val = TMR_W'(ERASE_CYC);
            default:    tmr_val = TMR_W'(RST_CYC);
        endcase
    end

    nand_busy_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(enter_busy), .clear(wp_kill),
        .val(tmr_val), .zero(tmr_zero)
    );

    assign walking   = (st == ST_PG_BUSY || st == ST_ER_BUSY) && !walk_done;
    assign mem_we    = walking && !wp_kill && !rst_cmd;
    assign walk_page = (st == ST_ER_BUSY) ? {page[PG_W-1:PG_BLK_W], walk_pib} : page;
    assign mem_addr  = walking ? (AW'(walk_page) * AW'(PAGE_B) + AW'(walk_col))
                               : (AW'(page) * AW'(PAGE_B) + AW'(col));
    assign mem_wdata = (st == ST_ER_BUSY) ? 8'hFF : (mem_rdata & pgbuf[walk_col]);

    nand_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
        .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_col  <= '0;
            walk_pib  <= '0;
            walk_done <= 1'b1;
        end else if (enter_busy) begin
            walk_col  <= '0;
            walk_pib  <= '0;
            walk_done <= !(st_nx == ST_PG_BUSY || st_nx == ST_ER_BUSY);
        end else if (mem_we) begin
            if (walk_col == COL_LAST) begin
                walk_col <= '0;
                if (st == ST_PG_BUSY || walk_pib == '1) walk_done <= 1'b1;
                else                                    walk_pib  <= walk_pib + 1'b1;
            end else begin
                walk_col <= walk_col + 1'b1;
            end
        end
    end

    // pointer, address, mode and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            area     <= AREA_LO;
            omode    <= OUT_NONE;
            col      <= '0;
            page     <= '0;
            addr_cnt <= '0;
            id_idx   <= '0;
            fail     <= 1'b0;
            for (int i = 0; i < PAGE_B; i++) pgbuf[i] <= 8'hFF;
        end else if (rst_cmd) begin
            area     <= AREA_LO;
            omode    <= OUT_NONE;
            addr_cnt <= '0;
            fail     <= 1'b0;
        end else begin
            if (wp_kill) fail <= 1'b1;
            if (is_cmd && io_in == CMD_STAT) omode <= OUT_STAT;
            if (cmd_live) begin
                addr_cnt <= '0;
                case (io_in)
                    CMD_RD_LO:  begin area <= AREA_LO; omode <= OUT_DATA; end
                    CMD_RD_HI:  begin area <= AREA_HI; omode <= OUT_DATA; end
                    CMD_RD_SP:  begin area <= AREA_SP; omode <= OUT_DATA; end
                    CMD_PG_SET: begin
                        fail  <= 1'b0;
                        omode <= OUT_NONE;
                        for (int i = 0; i < PAGE_B; i++) pgbuf[i] <= 8'hFF;
                    end
                    CMD_ER_SET: begin fail <= 1'b0; omode <= OUT_NONE; end
                    CMD_ID:     begin omode <= OUT_ID; id_idx <= '0; end
                    CMD_PG_GO:  begin if (go_pg_ok && !wp_n) fail <= 1'b1; omode <= OUT_NONE; end
                    CMD_ER_GO:  begin if (go_er_ok && !wp_n) fail <= 1'b1; omode <= OUT_NONE; end
                    default:    omode <= OUT_NONE;
                endcase
            end else if (is_adr && (st == ST_RD_ADDR || st == ST_PG_ADDR || st == ST_ER_ADDR)) begin
                if (addr_cnt != 2'd3) addr_cnt <= addr_cnt + 1'b1;
                if (st != ST_ER_ADDR && addr_cnt == 2'd0) begin
                    unique case (area)
                        AREA_LO: col <= {2'b00, io_in};
                        AREA_HI: col <= {2'b01, io_in};
                        default: col <= {6'b100000, io_in[3:0]};
                    endcase
                    if (area == AREA_HI) area <= AREA_LO;
                end
                if ((st != ST_ER_ADDR && addr_cnt == 2'd1) || (st == ST_ER_ADDR && addr_cnt == 2'd0))
                    page <= {io_in[5 +: BLK_W], io_in[PG_BLK_W-1:0]};
            end else if (is_dat && (st == ST_PG_DATA || (st == ST_PG_ADDR && addr_cnt == 2'd3))) begin
                pgbuf[col] <= io_in;
                if (col != COL_LAST) col <= col + 1'b1;
            end else if (re_rise) begin
                if (omode == OUT_DATA && st == ST_RD_DATA) begin
                    if (col == COL_LAST) begin
                        col  <= '0;
                        page <= page + 1'b1;
                    end else begin
                        col <= col + 1'b1;
                    end
                end else if (omode == OUT_ID && id_idx != 2'd3) begin
                    id_idx <= id_idx + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        rb_pull_low = busy_st;
        io_out      = 8'h00;
        io_oe       = 1'b0;
        unique case (omode)
            OUT_STAT: begin
                io_out = {wp_n, !busy_st, 5'b00000, fail && !busy_st};
                io_oe  = !ce_n && !re_n;
            end
            OUT_ID: begin
                case (id_idx)
                    2'd0:    io_out = ID_B0;
                    2'd1:    io_out = ID_B1;
                    2'd2:    io_out = ID_B2;
                    default: io_out = 8'h00;
                endcase
                io_oe = !ce_n && !re_n && (st == ST_ID_DATA);
            end
            OUT_DATA: begin
                io_out = mem_rdata;
                io_oe  = !ce_n && !re_n && (st == ST_RD_DATA);
            end
            default: io_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/nand_cmd_if_chk.sv
module nand_cmd_if_chk
    import nand_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             re_n,
    input logic             wp_n,
    input logic             io_oe,
    input logic             rb_pull_low,
    input st_e              st,
    input logic             mem_we,
    input logic [7:0]       mem_wdata,
    input logic [7:0]       mem_rdata,
    input logic [COL_W-1:0] col
);
    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !rb_pull_low);

    p_oe_gated_r14: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> (!ce_n && !re_n));

    p_col_in_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        col < COL_W'(PAGE_B));

    p_prog_clears_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && st == ST_PG_BUSY) |-> ((mem_wdata & ~mem_rdata) == 8'h00));

    p_erase_writes_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && st == ST_ER_BUSY) |-> (mem_wdata == 8'hFF));

    p_wp_stops_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wp_n) |-> !(st == ST_PG_BUSY || st == ST_ER_BUSY));
endmodule

bind nand_cmd_if nand_cmd_if_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .re_n(re_n), .wp_n(wp_n),
    .io_oe(io_oe), .rb_pull_low(rb_pull_low), .st(st), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .col(col)
);

// File: tb/nand_cmd_if_tb_top.sv
module nand_cmd_if_tb_top;
    localparam int READ_CYC  = 40;
    localparam int PROG_CYC  = 600;
    localparam int ERASE_CYC = 1200;
    localparam int RST_CYC   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, rb_pull_low;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    nand_cmd_if #(.READ_CYC(READ_CYC), .PROG_CYC(PROG_CYC),
                  .ERASE_CYC(ERASE_CYC), .RST_CYC(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .rb_pull_low(rb_pull_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_tests++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk);
        cle = c; ale = a; io_in = b; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);  wr(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b);  wr(1'b0, 1'b1, b); endtask
    task automatic din(input logic [7:0] b);  wr(1'b0, 1'b0, b); endtask

    task automatic addr3(input logic [7:0] c, input logic [7:0] p);
        adr(c); adr(p); adr(8'h00);
    endtask

    task automatic rd_byte(output logic [7:0] v, output logic oe);
        @(negedge clk);
        re_n = 1'b0;
        repeat (2) @(negedge clk);
        v = io_out; oe = io_oe;
        re_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (rb_pull_low && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // scoreboard: driver side pushes expectations
    task automatic expect_b(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    // monitor side: pulls bytes from the bus and compares with the queue
    task automatic pull(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            logic oe;
            logic [7:0] e;
            string t;
            rd_byte(v, oe);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {oe, v}, {1'b1, e});
        end
    endtask

    task automatic do_read(input logic [7:0] pc, input logic [7:0] c, input logic [7:0] p);
        int n;
        cmd(pc); addr3(c, p);
        wait_ready(n);
    endtask

    task automatic do_prog(input logic [7:0] c, input logic [7:0] p, input logic [7:0] b);
        int n;
        cmd(8'h80); addr3(c, p); din(b); cmd(8'h10);
        wait_ready(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] v;
        logic oe;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 busy after reset", rb_pull_low, 0);
        re_n = 1'b0; repeat (2) @(negedge clk);
        chk("R1 bus idle after reset", io_oe, 0);
        re_n = 1'b1; repeat (2) @(negedge clk);

        // R7/R8 erase block 0, status while busy
        cmd(8'h60); adr(8'h00); adr(8'h00); cmd(8'hD0);
        cmd(8'h70);
        expect_b(8'h80, "R8 status busy"); pull(1);
        wait_ready(n);
        expect_b(8'hC0, "R8 status ready pass"); pull(1);
        // R7 erase block 1 with timing
        cmd(8'h60); adr(8'h20); adr(8'h00); cmd(8'hD0);
        wait_ready(n);
        chk_rng("R7 erase busy cycles", n, ERASE_CYC - 4, ERASE_CYC + 2);

        // R6 program with timing
        cmd(8'h80); addr3(8'h00, 8'h00);
        din(8'h11); din(8'h22); din(8'h33); din(8'h44);
        cmd(8'h10);
        wait_ready(n);
        chk_rng("R6 program busy cycles", n, PROG_CYC - 4, PROG_CYC + 2);

        // R2 read with timing
        cmd(8'h00); addr3(8'h00, 8'h00);
        wait_ready(n);
        chk_rng("R2 read busy cycles", n, READ_CYC - 4, READ_CYC + 2);
        expect_b(8'h11, "R2 col0"); expect_b(8'h22, "R2 col1");
        expect_b(8'h33, "R2 col2"); expect_b(8'h44, "R2 col3");
        expect_b(8'hFF, "R2 col4 erased");
        pull(5);

        // R6 AND semantics
        do_prog(8'h00, 8'h00, 8'hF0);
        do_read(8'h00, 8'h00, 8'h00);
        expect_b(8'h10, "R6 bits only cleared"); pull(1);

        // R7 other block untouched and erased: block 1 page 0
        do_read(8'h00, 8'h00, 8'h20);
        expect_b(8'hFF, "R7 block1 erased"); pull(1);

        // R3 upper half then fallback
        cmd(8'h01); cmd(8'h80); addr3(8'h05, 8'h00); din(8'hAB); cmd(8'h10);
        wait_ready(n);
        do_prog(8'h05, 8'h00, 8'hCD);
        do_read(8'h01, 8'h05, 8'h00);
        expect_b(8'hAB, "R3 upper half col261"); pull(1);
        do_read(8'h00, 8'h05, 8'h00);
        expect_b(8'hCD, "R3 fallback to lower col5"); pull(1);

        // R4 spare area sticky until 00H
        do_read(8'h50, 8'h03, 8'h00);
        expect_b(8'hFF, "R4 spare col515 erased"); pull(1);
        do_prog(8'h03, 8'h00, 8'h5A);
        do_read(8'h50, 8'h03, 8'h00);
        expect_b(8'h5A, "R4 sticky spare col515"); pull(1);
        do_read(8'h00, 8'h03, 8'h00);
        expect_b(8'h44, "R4 00H restores lower col3"); pull(1);

        // R5 sequential wrap into next page
        do_prog(8'h00, 8'h01, 8'h77);
        do_read(8'h50, 8'h0E, 8'h00);
        expect_b(8'hFF, "R5 col526"); expect_b(8'hFF, "R5 col527");
        pull(2);
        chk("R5 busy on wrap", rb_pull_low, 1);
        wait_ready(n);
        chk_rng("R5 wrap busy cycles", n, READ_CYC - 6, READ_CYC + 2);
        expect_b(8'h77, "R5 next page col0"); pull(1);

        // R9 ID bytes
        cmd(8'h90); adr(8'h00);
        expect_b(8'h98, "R9 id0"); expect_b(8'h76, "R9 id1");
        expect_b(8'hA5, "R9 id2"); expect_b(8'h00, "R9 id3");
        pull(4);

        // R13 extra address byte ignored
        cmd(8'h00); addr3(8'h00, 8'h00); adr(8'h55);
        wait_ready(n);
        expect_b(8'h10, "R13 extra address ignored"); pull(1);

        // R11 write protect refuses program
        wp_n = 1'b0;
        cmd(8'h70);
        expect_b(8'h40, "R11 status protected"); pull(1);
        cmd(8'h80); addr3(8'h08, 8'h00); din(8'h00); cmd(8'h10);
        repeat (3) @(negedge clk);
        chk("R11 program refused no busy", rb_pull_low, 0);
        cmd(8'h70);
        expect_b(8'h41, "R11 refused sets fail"); pull(1);
        wp_n = 1'b1;
        do_read(8'h00, 8'h08, 8'h00);
        expect_b(8'hFF, "R11 array unchanged"); pull(1);

        // R11 write protect aborts erase in progress
        cmd(8'h60); adr(8'h20); adr(8'h00); cmd(8'hD0);
        repeat (50) @(negedge clk);
        chk("R11 erase running", rb_pull_low, 1);
        wp_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 abort releases busy", rb_pull_low, 0);
        cmd(8'h70);
        expect_b(8'h41, "R11 abort sets fail"); pull(1);
        wp_n = 1'b1;

        // R10 reset during busy
        cmd(8'h60); adr(8'h20); adr(8'h00); cmd(8'hD0);
        repeat (20) @(negedge clk);
        cmd(8'hFF);
        wait_ready(n);
        chk_rng("R10 reset busy cycles", n, RST_CYC - 4, RST_CYC + 2);
        cmd(8'h70);
        expect_b(8'hC0, "R10 fail cleared"); pull(1);
        cmd(8'h50); cmd(8'hFF); wait_ready(n);
        do_prog(8'h09, 8'h00, 8'h12);
        do_read(8'h00, 8'h09, 8'h00);
        expect_b(8'h12, "R10 reset restores lower area"); pull(1);

        // R12 unknown command
        cmd(8'h3C);
        rd_byte(v, oe);
        chk("R12 unknown command leaves bus undriven", oe, 0);

        // R14 no drive with read strobe high
        cmd(8'h70);
        repeat (2) @(negedge clk);
        chk("R14 no drive with re_n high", io_oe, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule